// File: doc/BRIEF.md
# Partitioned LED scan readout engine

The engine streams a monochrome frame out of a byte-wide frame memory and feeds the column shift drivers of a multiplexed LED panel. The frame is cut into horizontal partitions. Each partition gets its own serial column-data line, and all of these lines shift in lockstep. The engine issues every memory read address itself. The partition index sits in the lowest address bits, so one burst of consecutive reads collects the byte at the same row and column position from every partition.

Each returned byte is captured into the byte latch of its partition, under an active-low strobe decoded from the partition field. When the last partition's byte is in, a one-cycle load pulse copies all latches at once into per-partition parallel-to-serial shifters. The shifters advance at half the read rate, so the next burst of bytes is fetched while the current one shifts out. After a complete row has been shifted, a row-latch pulse tells the panel to display it and the row select advances. The panel is meanwhile fed the next row. All divided rates are single-cycle enables in the one system clock domain.

The default build matches a 256 by 1024 panel: 16 partitions of 16 rows, each row 1024 pixels (128 bytes), with a 32 KB frame. A synchronous clear input empties the byte latches and the shifters without disturbing any timing. Row count and bytes per row must be powers of two. The partition count is always twice the byte width, which makes one read burst last exactly as long as one byte takes to shift out.

Top module: `ledscan_engine`

## Requirements
- R1: Reads are issued as one-cycle `mem_rd` pulses spaced exactly RD_DIV cycles apart. The memory answers on `mem_rdata` in the cycle after `mem_rd`.
- R2: `mem_addr` = {1'b0, row, column byte, partition}, with the partition in the lowest PART_W bits, the column above it and the row in the top field. Successive reads count this index up by one from zero, so the partition changes fastest and the index wraps to zero after a whole frame.
- R3: In the cycle after a read, `part_strobe_n` has exactly one bit low: the bit whose index is that read's partition field. In every other cycle all strobe bits are high.
- R4: `load_pulse` is high for exactly the one cycle that follows the strobe of the last partition (index NPART-1).
- R5: Each load copies the latched bytes into the shifters. `ser_data[p]` then presents partition p's byte MSB first, one bit per period of 2*RD_DIV cycles. The bytes come from the row and column of that byte group.
- R6: `shift_pulse` is high in the last cycle of every bit period, which is the sampling point for the panel. The first such pulse comes 2*RD_DIV cycles after the first load, and no pulse comes before it. Exactly BYTE_W pulses fall in each load interval, and the final one coincides with the next load.
- R7: `row_latch` is high for one cycle, in the cycle after the `shift_pulse` that carries the last bit of a row's final byte group. `row_sel` advances by one in that same cycle and wraps from ROWS-1 to 0.
- R8: After reset, `mem_rd`, `load_pulse`, `shift_pulse`, `row_latch` and `ser_data` are 0, all strobe bits are high, and `row_sel` is ROWS-1, so the first completed row is shown as row 0.
- R9: `clr` zeroes all byte latches and shifters at the end of its cycle, and `ser_data` is all zero in the following cycle. A load in the same cycle is overridden, so that byte group is shifted out as zeros. Read, load, shift-pulse and row timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of byte latches and shifters |
| mem_rd | output | 1 | Read request to the frame memory |
| mem_addr | output | ADDR_W | Frame memory read address {0, row, column, partition} |
| mem_rdata | input | BYTE_W | Read data, valid the cycle after `mem_rd` |
| part_strobe_n | output | NPART | Active-low per-partition latch strobes |
| load_pulse | output | 1 | Latches-to-shifters transfer pulse |
| shift_pulse | output | 1 | Panel sampling enable, last cycle of each bit period |
| ser_data | output | NPART | Serial column data, one line per partition |
| row_latch | output | 1 | Display strobe for the completed row |
| row_sel | output | ROW_W | Row currently displayed |

## Verification
The bench builds the engine with a byte width of 2, four rows of four byte groups, and a read spacing of 2 cycles. These values give four partitions and a frame of 64 reads, which is 128 cycles. Every address, strobe, load, serial bit and row latch can then be compared against arithmetic expectations over several complete frames, including the wraps of the row select and of the address. A read spacing above one exercises the divider and keeps the latch strobes apart from the load cycle. This allows a clear pulse to be placed exactly on a load, to show a whole zeroed byte group followed by fully restored timing.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
  // Counter width for a modulus, at least one bit.
  function automatic int unsigned bits_for(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ledscan_addr_gen.sv
module ledscan_addr_gen #(
  parameter int RD_DIV = 1,
  parameter int PART_W = 4,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 4,
  localparam int IDX_W  = PART_W + COL_W + ROW_W,
  localparam int ADDR_W = IDX_W + 1,
  localparam int TC_W   = ledscan_pkg::bits_for(RD_DIV)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_v,
  output logic [PART_W-1:0] rd_part
);
  logic [TC_W-1:0]  tick_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign fire = (tick_q == TC_W'(RD_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q   <= '0;
      idx_q    <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      rd_v     <= 1'b0;
      rd_part  <= '0;
    end else begin
      tick_q <= fire ? '0 : tick_q + 1'b1;
      mem_rd <= fire;
      if (fire) begin
        mem_addr <= {1'b0, idx_q};
        idx_q    <= idx_q + 1'b1;
      end
      rd_v    <= mem_rd;
      rd_part <= mem_addr[PART_W-1:0];
    end
  end

  // Checker state: index of the previous read.
  logic             seen_q;
  logic [IDX_W-1:0] last_idx_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      last_idx_q <= '0;
    end else if (mem_rd) begin
      seen_q     <= 1'b1;
      last_idx_q <= mem_addr[IDX_W-1:0];
    end
  end

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && seen_q) |-> (mem_addr[IDX_W-1:0] == last_idx_q + 1'b1));
endmodule

// File: rtl/ledscan_latch_bank.sv
module ledscan_latch_bank #(
  parameter int BYTE_W = 8,
  localparam int NPART  = 2 * BYTE_W,
  localparam int PART_W = $clog2(NPART)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         rd_v,
  input  logic [PART_W-1:0]            rd_part,
  input  logic [BYTE_W-1:0]            mem_rdata,
  output logic [NPART-1:0]             strobe_n,
  output logic [NPART-1:0][BYTE_W-1:0] latched,
  output logic                         load
);
  always_comb begin
    strobe_n = '1;
    if (rd_v) strobe_n[rd_part] = 1'b0;
  end

  for (genvar p = 0; p < NPART; p++) begin : g_lat
    logic [BYTE_W-1:0] lat_q;
    always_ff @(posedge clk) begin
      if (rst || clr)       lat_q <= '0;
      else if (!strobe_n[p]) lat_q <= mem_rdata;
    end
    assign latched[p] = lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) load <= 1'b0;
    else     load <= rd_v && (rd_part == PART_W'(NPART - 1));
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~strobe_n));
  assert_load_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> $past(!strobe_n[NPART-1]));
endmodule

// File: rtl/ledscan_shift_bank.sv
module ledscan_shift_bank #(
  parameter int BYTE_W = 8,
  parameter int RD_DIV = 1,
  localparam int NPART   = 2 * BYTE_W,
  localparam int BIT_CYC = 2 * RD_DIV,
  localparam int PH_W    = ledscan_pkg::bits_for(BIT_CYC)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         load,
  input  logic [NPART-1:0][BYTE_W-1:0] latched,
  output logic [NPART-1:0]             ser_data,
  output logic                         shift_pulse
);
  logic [PH_W-1:0] ph_q, ph_n;
  logic            run_q, run_n;
  logic            bit_end;

  assign bit_end = (ph_q == PH_W'(BIT_CYC - 1));

  always_comb begin
    ph_n  = ph_q;
    run_n = run_q;
    if (load) begin
      ph_n  = '0;
      run_n = 1'b1;
    end else if (bit_end) begin
      ph_n = '0;
    end else begin
      ph_n = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= '0;
      run_q       <= 1'b0;
      shift_pulse <= 1'b0;
    end else begin
      ph_q        <= ph_n;
      run_q       <= run_n;
      shift_pulse <= run_n && (ph_n == PH_W'(BIT_CYC - 1));
    end
  end

  for (genvar p = 0; p < NPART; p++) begin : g_sh
    logic [BYTE_W-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst || clr)              sh_q <= '0;
      else if (load)               sh_q <= latched[p];
      else if (run_q && bit_end)   sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
    assign ser_data[p] = sh_q[BYTE_W-1];
  end

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> !shift_pulse);
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (ser_data == '0));
endmodule

// File: rtl/ledscan_row_ctrl.sv
module ledscan_row_ctrl #(
  parameter int COL_W = 7,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  output logic             row_latch,
  output logic [ROW_W-1:0] row_sel
);
  logic [COL_W-1:0] grp_q;
  logic             primed_q;
  logic             row_done;

  // A load of group 0 means the previous row's final bit has just been sampled.
  assign row_done = load && primed_q && (grp_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q     <= '0;
      primed_q  <= 1'b0;
      row_latch <= 1'b0;
      row_sel   <= '1;
    end else begin
      row_latch <= row_done;
      if (load) begin
        grp_q    <= grp_q + 1'b1;
        primed_q <= 1'b1;
      end
      if (row_done) row_sel <= row_sel + 1'b1;
    end
  end

  assert_row_advance_R7: assert property (@(posedge clk) disable iff (rst)
    row_latch |-> (row_sel == $past(row_sel) + 1'b1));
  assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !row_latch |-> $stable(row_sel));
endmodule

// File: rtl/ledscan_engine.sv
module ledscan_engine #(
  parameter int BYTE_W    = 8,
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 128,
  parameter int RD_DIV    = 1,
  localparam int NPART  = 2 * BYTE_W,
  localparam int PART_W = $clog2(NPART),
  localparam int COL_W  = $clog2(ROW_BYTES),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = PART_W + COL_W + ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [NPART-1:0]  part_strobe_n,
  output logic              load_pulse,
  output logic              shift_pulse,
  output logic [NPART-1:0]  ser_data,
  output logic              row_latch,
  output logic [ROW_W-1:0]  row_sel
);
  logic                         rd_v;
  logic [PART_W-1:0]            rd_part;
  logic [NPART-1:0][BYTE_W-1:0] latched;

  ledscan_addr_gen #(
    .RD_DIV(RD_DIV), .PART_W(PART_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_addr (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .rd_v(rd_v), .rd_part(rd_part)
  );

  ledscan_latch_bank #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst(rst), .clr(clr), .rd_v(rd_v), .rd_part(rd_part),
    .mem_rdata(mem_rdata), .strobe_n(part_strobe_n), .latched(latched),
    .load(load_pulse)
  );

  ledscan_shift_bank #(.BYTE_W(BYTE_W), .RD_DIV(RD_DIV)) u_shift (
    .clk(clk), .rst(rst), .clr(clr), .load(load_pulse), .latched(latched),
    .ser_data(ser_data), .shift_pulse(shift_pulse)
  );

  ledscan_row_ctrl #(.COL_W(COL_W), .ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .load(load_pulse),
    .row_latch(row_latch), .row_sel(row_sel)
  );
endmodule

// File: tb/ledscan_engine_test.sv
module ledscan_engine_test;
  localparam int BYTE_W = 2, ROWS = 4, ROW_BYTES = 4, RD_DIV = 2;
  localparam int NPART = 2 * BYTE_W;
  localparam int PART_W = $clog2(NPART), COL_W = $clog2(ROW_BYTES), ROW_W = $clog2(ROWS);
  localparam int ADDR_W = PART_W + COL_W + ROW_W + 1;
  localparam int FRAME_RD = NPART * ROW_BYTES * ROWS;
  localparam int FRAME_CYC = FRAME_RD * RD_DIV;
  localparam int BIT_CYC = 2 * RD_DIV;
  localparam int ROW_PULSES = BYTE_W * ROW_BYTES;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0;
  logic mem_rd, load_pulse, shift_pulse, row_latch;
  logic [ADDR_W-1:0] mem_addr;
  logic [BYTE_W-1:0] mem_rdata = '0;
  logic [NPART-1:0] part_strobe_n, ser_data;
  logic [ROW_W-1:0] row_sel;

  always #10 clk = ~clk;

  ledscan_engine #(.BYTE_W(BYTE_W), .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .RD_DIV(RD_DIV)) uut (
    .clk(clk), .rst(rst), .clr(clr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .part_strobe_n(part_strobe_n), .load_pulse(load_pulse),
    .shift_pulse(shift_pulse), .ser_data(ser_data), .row_latch(row_latch), .row_sel(row_sel)
  );

  function automatic logic [BYTE_W-1:0] pat(input int a);
    int v;
    v = a * 5 + (a >> 3) + 1;
    return v[BYTE_W-1:0];
  endfunction

  // Synchronous-read frame memory model.
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 0, arm_clr = 0, done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  int rd_cnt = 0, last_rd = -1, pend_part = -1, k = 0, last_load = -1;
  int load_cnt = 0, zero_group = -1, latch_cnt = 0, exp_row = ROWS - 1;
  bit prev_last_strobe = 0, prev_row_end = 0, clr_prev = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      logic [NPART-1:0] exp_sn, exp_ser;
      logic [BYTE_W-1:0] tb;
      bit exp_sp, row_end_now;
      int g, b, r, c;
      cyc++;
      // R1 / R2: read spacing and address sequence
      if (mem_rd) begin
        if (last_rd >= 0) check(cyc - last_rd == RD_DIV, "R1 read spacing", cyc - last_rd, RD_DIV);
        check(int'(mem_addr) == rd_cnt % FRAME_RD, "R2 read address", int'(mem_addr), rd_cnt % FRAME_RD);
        last_rd = cyc;
        rd_cnt++;
      end
      // R3: strobe follows the previous cycle's read
      exp_sn = '1;
      if (pend_part >= 0) exp_sn[pend_part] = 1'b0;
      check(part_strobe_n == exp_sn, "R3 partition strobe", int'(part_strobe_n), int'(exp_sn));
      // R4: load after last partition strobe
      check(load_pulse == prev_last_strobe, "R4 load pulse", int'(load_pulse), int'(prev_last_strobe));
      prev_last_strobe = (pend_part == NPART - 1);
      pend_part = mem_rd ? int'(mem_addr[PART_W-1:0]) : -1;
      // R9: shifters empty right after clear
      if (clr_prev) check(ser_data == '0, "R9 clear empties shifters", int'(ser_data), 0);
      // R6: shift pulse cadence
      exp_sp = (last_load >= 0) && (cyc != last_load) && ((cyc - last_load) % BIT_CYC == 0);
      check(shift_pulse == exp_sp, "R6 shift pulse", int'(shift_pulse), int'(exp_sp));
      row_end_now = 0;
      if (shift_pulse) begin
        g = k / BYTE_W;
        b = BYTE_W - 1 - (k % BYTE_W);
        r = (g / ROW_BYTES) % ROWS;
        c = g % ROW_BYTES;
        for (int p = 0; p < NPART; p++) begin
          tb = pat((r * ROW_BYTES + c) * NPART + p);
          exp_ser[p] = (g == zero_group) ? 1'b0 : tb[b];
        end
        check(ser_data == exp_ser, (g == zero_group) ? "R9 cleared group" : "R5 serial data",
              int'(ser_data), int'(exp_ser));
        row_end_now = ((k + 1) % ROW_PULSES == 0);
        k++;
      end
      // R7 / R8: row latch and row select
      check(row_latch == prev_row_end, "R7 row latch", int'(row_latch), int'(prev_row_end));
      if (row_latch) begin
        latch_cnt++;
        exp_row = (latch_cnt - 1) % ROWS;
      end
      check(int'(row_sel) == exp_row, (latch_cnt == 0) ? "R8 initial row select" : "R7 row select",
            int'(row_sel), exp_row);
      prev_row_end = row_end_now;
      // clear stimulus placed on a load cycle
      clr_prev = clr;
      if (arm_clr && load_pulse) begin
        clr = 1'b1;
        zero_group = load_cnt;
        arm_clr = 0;
      end else begin
        clr = 1'b0;
      end
      if (load_pulse) begin
        last_load = cyc;
        load_cnt++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(mem_rd == 1'b0, "R8 reset mem_rd", int'(mem_rd), 0);
    check(part_strobe_n == '1, "R8 reset strobes", int'(part_strobe_n), (1 << NPART) - 1);
    check(load_pulse == 1'b0 && shift_pulse == 1'b0, "R8 reset pulses",
          int'({load_pulse, shift_pulse}), 0);
    check(ser_data == '0, "R8 reset serial data", int'(ser_data), 0);
    check(row_latch == 1'b0, "R8 reset row latch", int'(row_latch), 0);
    check(int'(row_sel) == ROWS - 1, "R8 reset row select", int'(row_sel), ROWS - 1);
    rst = 1'b0;
    mon_en = 1;
    repeat (2 * FRAME_CYC) @(negedge clk);
    arm_clr = 1;
    repeat (3 * FRAME_CYC) @(negedge clk);
    check(zero_group >= 0, "R9 clear applied on a load", zero_group, 0);
    check(latch_cnt >= 4 * ROWS, "R7 rows completed", latch_cnt, 4 * ROWS);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule